// File: doc/BRIEF.md
# Equalizer Calibration Sweep Controller

This block is the control state machine that tunes a receive equalizer with nine adjustable settings. It tries a range of values for each setting in turn and asks an external measurement circuit for a quality score at every value. For each setting it keeps the value that scored best. Calibration runs a coarse phase with one step size, then a fine phase with another. Each phase repeats its full pass over the selected settings a programmable number of times.

The score comes back over a valid/ready channel. The controller pulses `meas_req` once after it has driven a new setting, then raises `score_ready` until `score_valid` is seen. A transfer takes place only in a cycle where both are high. A score offered while `score_ready` is low is ignored, and the source must hold it until it is taken. The configuration inputs must stay stable while `busy` is high. Dropping `enable` abandons a run and leaves the settings as they are.

Top module: `eqcal_sweep_ctrl`

## Requirements
- R1: After reset all settings are 0 and `busy`, `done`, `meas_req` and `score_ready` are low.
- R2: When `enable` is high and the block is idle, a calibration starts and `busy` goes high. Each setting occupies bits [7i+6:7i] of `eq_settings`.
- R3: Bit i of `sweep_mask` set to 1 selects setting i for sweeping in both phases. A setting whose bit is 0 keeps its value through the whole calibration.
- R4: A swept setting is driven to 0 first. After each measurement it rises by the phase step, clamped at 127, and its sweep ends once 127 has been measured. A step of 0 behaves as a step of 1.
- R5: The first score of a sweep is always recorded. A later score is recorded only if it is strictly greater than the recorded one, so on a tie the lower value is kept. When the sweep ends, the setting is driven to its recorded value.
- R6: Within a pass the selected settings are swept one at a time, in increasing index order.
- R7: The coarse phase runs `coarse_iters` passes using `coarse_step`. The fine phase then runs `fine_iters` passes using `fine_step`.
- R8: A phase with an all-zero mask or a zero iteration count completes without any measurement.
- R9: `meas_req` is a one-cycle pulse issued with the new setting already on `eq_settings`. A score is consumed only when `score_valid` and `score_ready` are both high. While the block is idle, `score_valid` has no effect.
- R10: When the fine phase completes, `done` goes high and `busy` goes low. `done` stays high until `enable` falls.
- R11: When `enable` is low, the next cycle has `busy` and `done` low, and the settings hold their current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable, active high |
| sweep_mask | input | 9 | Per-setting sweep select |
| coarse_step | input | 5 | Coarse phase increment |
| fine_step | input | 5 | Fine phase increment |
| coarse_iters | input | 7 | Coarse phase pass count |
| fine_iters | input | 7 | Fine phase pass count |
| meas_req | output | 1 | One-cycle request for a quality measurement |
| score_valid | input | 1 | Score channel valid |
| score_ready | output | 1 | Score channel ready |
| score | input | 12 | Quality score, larger is better |
| eq_settings | output | 63 | Nine 7-bit equalizer settings, setting 0 in the low bits |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration complete |

## Verification
A corrupted step, index or phase register shows up at the very next `meas_req`, because the settings vector presented with that pulse stops matching the value sequence expected from the mask and steps. Every request is compared against that sequence, so such a fault surfaces within one measurement. A fault in the best-value tracking is hidden until a sweep ends. It then appears as a wrong settled value on the first request for the following setting, or in the final settings once `done` rises. A broken pass or phase counter shows up as a missing or surplus measurement before `done`.

// File: rtl/eqcal_pkg.sv
package eqcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_SEL,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } eqcal_state_t;
endpackage

// File: rtl/eqcal_step_gen.sv
module eqcal_step_gen #(
  parameter int VAL_W  = 7,
  parameter int STEP_W = 5
) (
  input  logic [VAL_W-1:0]  cur_val,
  input  logic [STEP_W-1:0] step,
  output logic [VAL_W-1:0]  nxt_val,
  output logic              at_max
);
  localparam logic [VAL_W:0] MAX_EXT = {1'b0, {VAL_W{1'b1}}};

  logic [STEP_W-1:0] eff_step;
  logic [VAL_W:0]    sum;

  always_comb begin
    eff_step = (step == '0) ? STEP_W'(1) : step;
    sum      = {1'b0, cur_val} + (VAL_W+1)'(eff_step);
    nxt_val  = (sum > MAX_EXT) ? {VAL_W{1'b1}} : sum[VAL_W-1:0];
    at_max   = (cur_val == {VAL_W{1'b1}});
  end
endmodule

// File: rtl/eqcal_best_track.sv
module eqcal_best_track #(
  parameter int VAL_W   = 7,
  parameter int SCORE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               sample,
  input  logic [SCORE_W-1:0] score,
  input  logic [VAL_W-1:0]   value,
  output logic [VAL_W-1:0]   win_val
);
  logic               have;
  logic [SCORE_W-1:0] best_score;
  logic [VAL_W-1:0]   best_val;
  logic               take;

  always_comb begin
    take    = !have || (score > best_score);
    win_val = take ? value : best_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have       <= 1'b0;
      best_score <= '0;
      best_val   <= '0;
    end else if (sample && take) begin
      have       <= 1'b1;
      best_score <= score;
      best_val   <= value;
    end
  end
endmodule

// File: rtl/eqcal_settings_bank.sv
module eqcal_settings_bank #(
  parameter int NUM_VARS = 9,
  parameter int VAL_W    = 7,
  parameter int IDX_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [VAL_W-1:0]          wr_val,
  output logic [NUM_VARS*VAL_W-1:0] settings
);
  for (genvar i = 0; i < NUM_VARS; i++) begin : g_var
    logic [VAL_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        val_q <= wr_val;
    end
    assign settings[i*VAL_W +: VAL_W] = val_q;
  end
endmodule

// File: rtl/eqcal_sweep_ctrl.sv
module eqcal_sweep_ctrl
  import eqcal_pkg::*;
#(
  parameter int NUM_VARS = 9,
  parameter int VAL_W    = 7,
  parameter int STEP_W   = 5,
  parameter int ITER_W   = 7,
  parameter int SCORE_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [NUM_VARS-1:0]       sweep_mask,
  input  logic [STEP_W-1:0]         coarse_step,
  input  logic [STEP_W-1:0]         fine_step,
  input  logic [ITER_W-1:0]         coarse_iters,
  input  logic [ITER_W-1:0]         fine_iters,
  output logic                      meas_req,
  input  logic                      score_valid,
  output logic                      score_ready,
  input  logic [SCORE_W-1:0]        score,
  output logic [NUM_VARS*VAL_W-1:0] eq_settings,
  output logic                      busy,
  output logic                      done
);
  localparam int IDX_W = $clog2(NUM_VARS + 1);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(NUM_VARS);

  eqcal_state_t      state;
  logic              phase_fine;
  logic [ITER_W-1:0] iter_cnt;
  logic [IDX_W-1:0]  var_idx;
  logic [VAL_W-1:0]  cur_val;

  logic [STEP_W-1:0] act_step;
  logic [ITER_W-1:0] act_iters;
  logic [NUM_VARS:0] mask_ext;
  logic              sel_bit;
  logic              accept;
  logic [VAL_W-1:0]  nxt_val;
  logic              at_max;
  logic [VAL_W-1:0]  win_val;
  logic              wr_en;
  logic [VAL_W-1:0]  wr_val;

  always_comb begin
    act_step  = phase_fine ? fine_step : coarse_step;
    act_iters = phase_fine ? fine_iters : coarse_iters;
    mask_ext  = {1'b0, sweep_mask};
    sel_bit   = mask_ext[var_idx];
    accept    = (state == ST_WAIT) && score_valid && enable;
  end

  eqcal_step_gen #(.VAL_W(VAL_W), .STEP_W(STEP_W)) u_step (
    .cur_val (cur_val),
    .step    (act_step),
    .nxt_val (nxt_val),
    .at_max  (at_max)
  );

  eqcal_best_track #(.VAL_W(VAL_W), .SCORE_W(SCORE_W)) u_best (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state == ST_SEL),
    .sample  (accept),
    .score   (score),
    .value   (cur_val),
    .win_val (win_val)
  );

  always_comb begin
    wr_en  = 1'b0;
    wr_val = '0;
    if (enable && (state == ST_SEL) && (var_idx != END_IDX) && sel_bit) begin
      wr_en  = 1'b1;
      wr_val = '0;
    end else if (accept) begin
      wr_en  = 1'b1;
      wr_val = at_max ? win_val : nxt_val;
    end
  end

  eqcal_settings_bank #(.NUM_VARS(NUM_VARS), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (var_idx),
    .wr_val   (wr_val),
    .settings (eq_settings)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase_fine <= 1'b0;
      iter_cnt   <= '0;
      var_idx    <= '0;
      cur_val    <= '0;
    end else if (!enable) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          phase_fine <= 1'b0;
          iter_cnt   <= '0;
          state      <= ST_CHK;
        end
        ST_CHK: begin
          if ((iter_cnt == act_iters) || (sweep_mask == '0)) begin
            if (!phase_fine) begin
              phase_fine <= 1'b1;
              iter_cnt   <= '0;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            var_idx <= '0;
            state   <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (var_idx == END_IDX) begin
            iter_cnt <= iter_cnt + ITER_W'(1);
            state    <= ST_CHK;
          end else if (sel_bit) begin
            cur_val <= '0;
            state   <= ST_REQ;
          end else begin
            var_idx <= var_idx + IDX_W'(1);
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (score_valid) begin
            if (at_max) begin
              var_idx <= var_idx + IDX_W'(1);
              state   <= ST_SEL;
            end else begin
              cur_val <= nxt_val;
              state   <= ST_REQ;
            end
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    meas_req    = (state == ST_REQ);
    score_ready = (state == ST_WAIT);
    busy        = (state != ST_IDLE) && (state != ST_DONE);
    done        = (state == ST_DONE);
  end
endmodule

// File: rtl/eqcal_sweep_checker.sv
module eqcal_sweep_checker #(
  parameter int SET_W = 63
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             meas_req,
  input logic             score_ready,
  input logic [SET_W-1:0] eq_settings,
  input logic             busy,
  input logic             done
);
  a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |=> !meas_req);

  a_r9_req_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |=> (score_ready || !busy));

  a_r9_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req || score_ready) |-> busy);

  a_r10_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !done));

  a_r11_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(eq_settings));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> done);
endmodule

bind eqcal_sweep_ctrl eqcal_sweep_checker #(.SET_W(NUM_VARS*VAL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .meas_req    (meas_req),
  .score_ready (score_ready),
  .eq_settings (eq_settings),
  .busy        (busy),
  .done        (done)
);

// File: tb/eqcal_sweep_ctrl_test.sv
module eqcal_sweep_ctrl_test;
  localparam int NV = 9;
  localparam int VW = 7;
  localparam int SW = 12;
  localparam int TOT = NV * VW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           enable = 1'b0;
  logic [NV-1:0]  sweep_mask = '0;
  logic [4:0]     coarse_step = 5'd2, fine_step = 5'd1;
  logic [6:0]     coarse_iters = 7'd2, fine_iters = 7'd4;
  logic           meas_req, score_ready, busy, done;
  logic           score_valid = 1'b0;
  logic [SW-1:0]  score = '0;
  logic [TOT-1:0] eq_settings;

  always #2 clk = ~clk;

  eqcal_sweep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sweep_mask(sweep_mask),
    .coarse_step(coarse_step), .fine_step(fine_step),
    .coarse_iters(coarse_iters), .fine_iters(fine_iters),
    .meas_req(meas_req), .score_valid(score_valid), .score_ready(score_ready),
    .score(score), .eq_settings(eq_settings), .busy(busy), .done(done)
  );

  typedef struct packed {
    logic [8:0]  mask;
    logic [4:0]  cs;
    logic [4:0]  fs;
    logic [6:0]  ci;
    logic [6:0]  fi;
    logic [1:0]  lat;
    logic [62:0] tgt;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{9'h1FD, 5'd2,  5'd1,  7'd2, 7'd4, 2'd0,
      {7'd120, 7'd55, 7'd90, 7'd3, 7'd64, 7'd100, 7'd13, 7'd77, 7'd40}},
    '{9'h101, 5'd30, 5'd4,  7'd1, 7'd1, 2'd2,
      {7'd127, 7'd55, 7'd90, 7'd3, 7'd64, 7'd100, 7'd13, 7'd77, 7'd6}},
    '{9'h02A, 5'd31, 5'd0,  7'd3, 7'd1, 2'd1,
      {7'd127, 7'd55, 7'd90, 7'd126, 7'd64, 7'd31, 7'd13, 7'd50, 7'd6}},
    '{9'h1FF, 5'd16, 5'd16, 7'd0, 7'd2, 2'd3,
      {7'd100, 7'd33, 7'd70, 7'd64, 7'd0, 7'd119, 7'd127, 7'd24, 7'd8}}
  };

  int n_chk = 0;
  int n_bad = 0;
  logic [TOT-1:0] exp_vec = '0;
  bit lost = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [SW-1:0] score_of(input logic [TOT-1:0] s,
                                               input logic [TOT-1:0] t);
    int sum = 0;
    for (int j = 0; j < NV; j++) begin
      int a = int'(s[j*VW +: VW]);
      int b = int'(t[j*VW +: VW]);
      sum += (a > b) ? a - b : b - a;
    end
    return SW'(4095 - sum);
  endfunction

  task automatic wait_req();
    int g = 0;
    while (!meas_req && g < 3000) begin
      @(negedge clk);
      g++;
    end
    if (!meas_req) begin
      lost = 1'b1;
      chk(1'b0, "R9 request missing", 0, 1);
    end
  endtask

  task automatic respond(input logic [SW-1:0] sc, input int lat);
    repeat (lat) @(negedge clk);
    score_valid = 1'b1;
    score       = sc;
    while (!score_ready) @(negedge clk);
    @(negedge clk);
    score_valid = 1'b0;
    score       = '0;
  endtask

  task automatic wait_done(output int extra);
    int g = 0;
    extra = 0;
    while (!done && g < 200) begin
      if (meas_req) extra++;
      @(negedge clk);
      g++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int extra;
    sweep_mask   = v.mask;
    coarse_step  = v.cs;
    fine_step    = v.fs;
    coarse_iters = v.ci;
    fine_iters   = v.fi;
    lost         = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 1);
    for (int ph = 0; ph < 2; ph++) begin
      int st  = (ph == 0) ? int'(v.cs) : int'(v.fs);
      int its = (ph == 0) ? int'(v.ci) : int'(v.fi);
      if (st == 0) st = 1;
      if (v.mask == '0) its = 0;
      for (int it = 0; it < its; it++) begin
        for (int i = 0; i < NV; i++) begin
          if (v.mask[i] && !lost) begin
            bit          have = 1'b0;
            logic [SW-1:0] best = '0;
            int          bv = 0;
            int          val = 0;
            forever begin
              logic [SW-1:0] sc;
              exp_vec[i*VW +: VW] = VW'(val);
              wait_req();
              if (lost) break;
              // R4 R6: value sequence and setting order seen with each request
              chk(eq_settings == exp_vec, "R4/R6 settings at request",
                  64'(eq_settings), 64'(exp_vec));
              sc = score_of(exp_vec, v.tgt);
              if (!have || sc > best) begin
                have = 1'b1;
                best = sc;
                bv   = val;
              end
              respond(sc, int'(v.lat));
              if (val == 127) break;
              val = (val + st > 127) ? 127 : val + st;
            end
            exp_vec[i*VW +: VW] = VW'(bv);
          end
        end
      end
    end
    wait_done(extra);
    chk(done == 1'b1 && busy == 1'b0, "R10 done after fine phase",
        64'({done, busy}), 64'(2'b10));
    // R5 R7 R3: settled values after both phases
    chk(eq_settings == exp_vec, "R5/R7 final settings",
        64'(eq_settings), 64'(exp_vec));
    chk(extra == 0, "R7 surplus measurements", 64'(extra), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10 done held", 64'(done), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 done cleared by enable low",
        64'({done, busy}), 0);
  endtask

  task automatic run_empty(input logic [8:0] m, input logic [6:0] ci,
                           input logic [6:0] fi);
    int extra;
    logic [TOT-1:0] snap;
    snap         = eq_settings;
    sweep_mask   = m;
    coarse_iters = ci;
    fine_iters   = fi;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    wait_done(extra);
    chk(extra == 0, "R8 no measurement", 64'(extra), 0);
    chk(done == 1'b1, "R8 completes", 64'(done), 1);
    chk(eq_settings == snap, "R8 settings unchanged", 64'(eq_settings), 64'(snap));
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(eq_settings == '0, "R1 settings zero", 64'(eq_settings), 0);
    chk({busy, done, meas_req, score_ready} == 4'b0, "R1 flags low",
        64'({busy, done, meas_req, score_ready}), 0);

    // R9: score offered while idle is ignored
    score_valid = 1'b1;
    score       = '1;
    repeat (5) @(negedge clk);
    chk(eq_settings == '0 && busy == 1'b0, "R9 idle score ignored",
        64'(eq_settings), 0);
    score_valid = 1'b0;
    score       = '0;

    for (int k = 0; k < 4; k++) run_vec(VECS[k]);

    // R11: abort mid-sweep keeps settings
    begin
      logic [TOT-1:0] snap;
      vec_t v = VECS[1];
      sweep_mask   = v.mask;
      coarse_step  = v.cs;
      fine_step    = v.fs;
      coarse_iters = v.ci;
      fine_iters   = v.fi;
      @(negedge clk);
      enable = 1'b1;
      wait_req();
      respond(score_of(eq_settings, v.tgt), 1);
      wait_req();
      snap   = eq_settings;
      enable = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R11 idle after enable low",
          64'({busy, done}), 0);
      repeat (5) @(negedge clk);
      chk(eq_settings == snap, "R11 settings kept", 64'(eq_settings), 64'(snap));
      chk(meas_req == 1'b0, "R11 no request while idle", 64'(meas_req), 0);
    end

    run_empty(9'h000, 7'd3, 7'd3);
    run_empty(9'h1FF, 7'd0, 7'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule